// File: doc/BRIEF.md
# Negacyclic Power-of-Two Polynomial Multiplier

This block multiplies a public polynomial by a small secret polynomial in the ring of polynomials modulo x^N + 1. N is 256 by default. Coefficients are kept modulo q = 2^QW, with QW = 13 by default. Because q is a power of two, every coefficient result is reduced by dropping the bits above QW, and no modular reduction logic is needed. A prime modulus is not assumed, so no number-theoretic transform is used. The product is built schoolbook style, using Horner's rule over the secret coefficients.

A host first writes the public coefficients and the secret coefficients through one write port, with a select bit choosing between the two stores. The secret coefficients are small signed values held in two's complement. A start pulse then begins the multiply. The block makes N passes, one cycle each, taking the secret coefficients from the highest index down to the lowest. In each pass, every accumulator lane first takes its neighbour's value, which multiplies the partial result by x. Lane 0 takes the negated value of the top lane, because x^N equals -1 in this ring. Each lane then adds the current secret coefficient times its own public coefficient. When the passes end, a one-cycle done pulse is raised and the product can be read back through an address-indexed read port.

Top module: `negacyclic_mult`

## Requirements
- R1: After reset, busy and done are 0 and every result coefficient read through the read port is 0.
- R2: A write with wr_sel = 0 stores wr_data as public coefficient wr_addr. A write with wr_sel = 1 stores only the low SW bits of wr_data as secret coefficient wr_addr, read as a two's complement value. With SW = 4, wr_data = 0x00FF stores -1.
- R3: A start pulse sampled while idle raises busy on the next cycle. On the N-th clock edge after that sampling edge, busy falls and done rises. Done stays high for exactly one cycle.
- R4: After done, result coefficient k equals the sum of a[i]*s[j] over all i+j = k, minus the sum of a[i]*s[j] over all i+j = k+N, taken modulo 2^QW.
- R5: A term that wraps past degree N-1 is subtracted. For example, a = x and s = x^(N-1) give result coefficient 0 equal to 2^QW - 1, and all other coefficients equal to 0.
- R6: Writes to either store are ignored while busy is high. The result of the current run uses the coefficients that were present when start was sampled.
- R7: A start pulse sampled while busy is ignored. It neither restarts nor lengthens the run.
- R8: While idle, the result coefficients hold their values until the next accepted start, even if either store is written in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Coefficient write strobe |
| wr_sel | input | 1 | Store select: 0 public, 1 secret |
| wr_addr | input | log2(N) | Coefficient index for the write |
| wr_data | input | QW | Coefficient value; the secret store keeps the low SW bits |
| start | input | 1 | Begin a multiply (accepted only when idle) |
| rd_addr | input | log2(N) | Result coefficient index |
| rd_data | output | QW | Result coefficient modulo 2^QW |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse when the result is complete |

## Verification
The assertions assume that start and the write strobe are synchronous single-cycle or level controls, with no other restriction. The checks on counter progress and held state therefore cover the cases where start and writes arrive during a run. The bench deliberately drives both of those cases, so these properties see stimulus that could break them. Secret values stay within the signed SW-bit range, and the bench draws them from -smax..smax with smax at most 7, so the reference product matches the value the hardware sign-extends. Public coefficients cover the full QW-bit range, including the all-ones value that makes every partial product wrap.

// File: rtl/nm_pkg.sv
package nm_pkg;
   typedef enum logic {
      SEL_PUB = 1'b0,
      SEL_SEC = 1'b1
   } store_sel_e;
endpackage

// File: rtl/nm_lane.sv
module nm_lane #(
   parameter int QW = 13,
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_we,
   input  logic [QW-1:0] a_wdata,
   input  logic          clr,
   input  logic          en,
   input  logic [QW-1:0] prev,
   input  logic [SW-1:0] s_coef,
   output logic [QW-1:0] acc
);
   logic [QW-1:0] a_q;
   logic [QW-1:0] s_ext;
   logic [QW-1:0] prod;

   assign s_ext = QW'($signed(s_coef));
   assign prod  = s_ext * a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a_q <= '0;
      else if (a_we) a_q <= a_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= prev + prod;
   end

   // R6
   coef_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(a_q));
   // R8
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(acc));
endmodule

// File: rtl/nm_seq.sv
module nm_seq #(
   parameter int N  = 256,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          clr,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] cnt
);
   assign clr = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (clr) begin
            busy <= 1'b1;
            cnt  <= AW'(N - 1);
         end else if (busy) begin
            if (cnt == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R3
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> (busy && cnt == AW'($past(cnt) - 1'b1)));
endmodule

// File: rtl/negacyclic_mult.sv
module negacyclic_mult #(
   parameter int N      = 256,
   parameter int QW     = 13,
   parameter int SW     = 4,
   parameter bit RD_REG = 1'b0,
   localparam int AW    = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [AW-1:0] wr_addr,
   input  logic [QW-1:0] wr_data,
   input  logic          start,
   input  logic [AW-1:0] rd_addr,
   output logic [QW-1:0] rd_data,
   output logic          busy,
   output logic          done
);
   import nm_pkg::*;

   if (N < 2 || (1 << AW) != N) begin : g_bad_n
      $error("N must be a power of two, at least 2");
   end
   if (QW < 1 || QW > 16) begin : g_bad_qw
      $error("QW must lie in 1..16");
   end
   if (SW < 2 || SW > QW) begin : g_bad_sw
      $error("SW must lie in 2..QW");
   end

   logic          clr;
   logic [AW-1:0] cnt;
   logic [QW-1:0] acc_w [N];
   logic [SW-1:0] sec_q [N];
   logic          wr_ok;

   assign wr_ok = wr_en && !busy;

   nm_seq #(.N(N), .AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .clr(clr), .busy(busy), .done(done), .cnt(cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) sec_q[i] <= '0;
      end else if (wr_ok && wr_sel == SEL_SEC) begin
         sec_q[wr_addr] <= wr_data[SW-1:0];
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_lane
      logic [QW-1:0] prev;
      if (g == 0) begin : g_wrap
         assign prev = QW'(0) - acc_w[N-1];
      end else begin : g_shift
         assign prev = acc_w[g-1];
      end
      nm_lane #(.QW(QW), .SW(SW)) u_lane (
         .clk(clk), .rst_n(rst_n),
         .a_we(wr_ok && wr_sel == SEL_PUB && wr_addr == AW'(g)),
         .a_wdata(wr_data), .clr(clr), .en(busy),
         .prev(prev), .s_coef(sec_q[cnt]), .acc(acc_w[g])
      );
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= acc_w[rd_addr];
      end
   end else begin : g_rd_comb
      assign rd_data = acc_w[rd_addr];
   end

   // R1
   idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: tb/tb_negacyclic_mult.sv
module tb_negacyclic_mult;
   localparam int N  = 256;
   localparam int QW = 13;
   localparam int SW = 4;
   localparam int AW = $clog2(N);
   localparam int MASK = (1 << QW) - 1;

   // columns: seed, secret magnitude bound, public mode (0 random, 1 all ones)
   localparam int unsigned VEC [4][3] = '{
      '{32'h0000_1234, 4, 0},
      '{32'h0000_BEEF, 1, 0},
      '{32'h0005_5AA5, 7, 0},
      '{32'h0000_0077, 3, 1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [QW-1:0] wr_data = '0;
   logic          start = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [QW-1:0] rd_data;
   logic          busy, done;

   int checks = 0;
   int errors = 0;
   int ta [N];
   int ts [N];
   int ex [N];
   int unsigned lcg;

   always #10 clk = ~clk;

   negacyclic_mult #(.N(N), .QW(QW), .SW(SW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
   );

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int unsigned rnd();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return lcg >> 8;
   endfunction

   task automatic wr(input logic sel, input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(addr); wr_data = QW'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_all();
      for (int i = 0; i < N; i++) wr(1'b0, i, ta[i]);
      for (int i = 0; i < N; i++) wr(1'b1, i, ts[i]);
   endtask

   task automatic reference();
      for (int k = 0; k < N; k++) begin
         int sum = 0;
         for (int i = 0; i < N; i++) begin
            if (k - i >= 0) sum += ta[i] * ts[k-i];
            else            sum -= ta[i] * ts[k-i+N];
         end
         ex[k] = sum & MASK;
      end
   endtask

   // drives start, returns number of posedges until done is seen
   task automatic run(output int cyc, input bit poke);
      @(negedge clk);
      start = 1'b1;
      cyc = 0;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 2 * N) begin
         if (poke && cyc == 40) begin
            start = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_addr = '0; wr_data = QW'(12'h5A5);
         end else if (poke && cyc == 41) begin
            start = 1'b0; wr_sel = 1'b1; wr_addr = AW'(5); wr_data = QW'(3);
         end else begin
            start = 1'b0; wr_en = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      wr_en = 1'b0; start = 1'b0;
   endtask

   task automatic compare_all(input string req);
      for (int k = 0; k < N; k++) begin
         rd_addr = AW'(k);
         #1;
         check(req, int'(rd_data), ex[k]);
      end
   endtask

   task automatic clear_ops();
      for (int i = 0; i < N; i++) begin ta[i] = 0; ts[i] = 0; end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int cyc;
      int hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(done), 0);
      rd_addr = '0; #1; check("R1 coef0", int'(rd_data), 0);
      rd_addr = AW'(N-1); #1; check("R1 coefN-1", int'(rd_data), 0);

      // R4 table of vectors against the reference product
      for (int v = 0; v < 4; v++) begin
         int smax = int'(VEC[v][1]);
         lcg = VEC[v][0];
         for (int i = 0; i < N; i++) begin
            ta[i] = (VEC[v][2] == 1) ? MASK : int'(rnd() & MASK);
            ts[i] = int'(rnd() % unsigned'(2 * smax + 1)) - smax;
         end
         load_all();
         reference();
         run(cyc, 1'b0);
         // R3 done after N edges following the sampling edge
         check("R3 latency", cyc, N + 1);
         @(negedge clk);
         check("R3 done width", int'(done), 0);
         compare_all("R4");
      end

      // R5 wraparound subtracts
      clear_ops();
      ta[1] = 1; ts[N-1] = 1;
      load_all();
      reference();
      run(cyc, 1'b0);
      rd_addr = '0; #1;
      check("R5 coef0", int'(rd_data), MASK);
      compare_all("R5");

      // R2 secret truncation and sign
      clear_ops();
      ta[3] = MASK;
      load_all();
      wr(1'b1, 0, 16'h00FF);
      ts[0] = -1;
      reference();
      run(cyc, 1'b0);
      rd_addr = AW'(3); #1;
      check("R2 coef3", int'(rd_data), 1);
      compare_all("R2");

      // R6 and R7 writes and start during a run
      lcg = 32'h0BAD_F00D;
      for (int i = 0; i < N; i++) begin
         ta[i] = int'(rnd() & MASK);
         ts[i] = int'(rnd() % 9) - 4;
      end
      load_all();
      reference();
      run(cyc, 1'b1);
      check("R7 latency", cyc, N + 1);
      compare_all("R6");

      // R8 results held while idle, even across writes
      rd_addr = AW'(7); #1;
      hold = int'(rd_data);
      wr(1'b0, 7, 123);
      wr(1'b1, 0, 2);
      repeat (5) @(negedge clk);
      rd_addr = AW'(7); #1;
      check("R8 hold", int'(rd_data), hold);
      check("R8 idle", int'(busy), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule